// File: doc/BRIEF.md
# Auxiliary UART register front end

This block is the register-side front end of a small auxiliary UART. A 32-bit register bus reads and writes word-aligned offsets. Received bytes arrive on a byte stream with a valid/ready handshake and are kept in a circular receive FIFO. The bus drains that FIFO through the data register. Each byte written to the data register leaves on a one-cycle transmit strobe with its byte value.

The transmitter is treated as always idle and empty, so the transmit interrupt depends only on its enable bit. The receive interrupt is pending while its enable is set and the FIFO holds data. The block provides the interrupt-enable, interrupt-identify, line-status and extended-status views, plus one level interrupt output. Baud generation, bit-level serialization and the modem/line control registers belong elsewhere.

Bus reads are combinational in the cycle that `bus_sel` is high with `bus_wr` low. Their side effects, such as a FIFO pop, take place at the clock edge that closes the access.

Top module: `mu_regfront`

## Requirements
- R1: After reset the FIFO is empty, the enable bits are 0, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: A write to offset 0x44 keeps only bit 0 (receive enable) and bit 1 (transmit enable). A read of 0x44 returns those bits ORed with 0xC0.
- R3: `irq` is high when transmit is enabled, or when receive is enabled and the FIFO is not empty. A read of offset 0x00 returns 1 in that case and 0 otherwise.
- R4: A read of offset 0x48 returns 0xC0 ORed with a source code and a flag. The code is 0x4 when the FIFO holds data and 0x2 otherwise. The flag is bit 0, which is set when nothing is pending.
- R5: A write to 0x48 with bit 1 set empties the FIFO, and a byte arriving in that same cycle is dropped. A write with bit 1 clear leaves the FIFO unchanged.
- R6: A read of offset 0x40 returns bytes in arrival order in bits 7:0, and the read pointer wraps past the last slot.
- R7: A read of 0x40 while the FIFO is empty returns the entry at the read pointer and changes no state.
- R8: A read of offset 0x54 returns 0x60, with bit 0 set while the FIFO holds data.
- R9: A read of offset 0x64 returns 0x30E, ORed with bit 0 while data is present and with the fill count placed in bits 16 and up.
- R10: Offset 0x60 reads 0x3 and offset 0x04 reads 0x1. Reads at any other offset return 0. Writes to offsets other than 0x40, 0x44 and 0x48 change no state.
- R11: `rx_ready` is low exactly when the FIFO holds DEPTH (8) bytes, and a byte offered while it is full is not stored.
- R12: When a data-register read and an accepted byte share a cycle, both take effect and the fill count is unchanged.
- R13: A write to 0x40 raises `tx_valid` for exactly the next cycle, with `tx_byte` equal to bits 7:0 of the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due in the same cycle as the access, so the bench samples `bus_rdata` in the middle of the low clock phase, before the edge that commits a pop. Pushes, pops, flushes and enable writes take effect at the closing edge. `irq`, `rx_ready` and all status views reflect them from the falling edge that follows, which is where the bench checks them. The transmit strobe comes from a register, so it is checked one falling edge after the write and found low again on the next.

// File: rtl/mu_pkg.sv
// Shared offsets and constants for the auxiliary UART register front end.
// Assumes word-aligned byte offsets within an 8-bit window.
package mu_pkg;
    localparam logic [7:0] OFF_AGG   = 8'h00;
    localparam logic [7:0] OFF_ENA   = 8'h04;
    localparam logic [7:0] OFF_DATA  = 8'h40;
    localparam logic [7:0] OFF_IEN   = 8'h44;
    localparam logic [7:0] OFF_IID   = 8'h48;
    localparam logic [7:0] OFF_LSTAT = 8'h54;
    localparam logic [7:0] OFF_CTRL  = 8'h60;
    localparam logic [7:0] OFF_XSTAT = 8'h64;

    localparam logic [31:0] FIFO_ON_BITS = 32'h0000_00C0;
    localparam logic [31:0] LSTAT_BASE   = 32'h0000_0060;
    localparam logic [31:0] XSTAT_BASE   = 32'h0000_030E;
    localparam int          XSTAT_LVL_LSB = 16;
endpackage

// File: rtl/mu_rxfifo.sv
// Circular receive FIFO: a read pointer plus a fill count, with the write
// slot derived as (read pointer + count) mod DEPTH. A pop of an empty FIFO
// is ignored. A flush clears the count, wins over a same-cycle push and
// leaves the read pointer in place.
module mu_rxfifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [DW-1:0]    push_data,
    output logic             push_ready,
    input  logic             pop,
    input  logic             flush,
    output logic [DW-1:0]    head_data,
    output logic [CNT_W-1:0] level
);
    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   slot_sum;
    logic [PTR_W-1:0] wr_slot;
    logic             do_push;
    logic             do_pop;

    // Handshake and qualified push/pop.
    always_comb begin
        push_ready = (cnt < CNT_W'(DEPTH));
        do_push    = push_valid && push_ready && !flush;
        do_pop     = pop && (cnt != '0);
    end

    // Write slot = read pointer + count, folded back into range.
    always_comb begin
        slot_sum = (CNT_W+1)'(rd_ptr) + (CNT_W+1)'(cnt);
        if (slot_sum >= (CNT_W+1)'(DEPTH))
            wr_slot = PTR_W'(slot_sum - (CNT_W+1)'(DEPTH));
        else
            wr_slot = PTR_W'(slot_sum);
    end

    // Storage: written on an accepted push, never reset.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_slot] <= push_data;
    end

    // Read pointer advances with wraparound on a real pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (do_pop)
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end

    // Fill count: cleared by flush, otherwise +push -pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    assign head_data = mem[rd_ptr];
    assign level     = cnt;
endmodule

// File: rtl/mu_irq_logic.sv
// Interrupt-enable register and pending logic. The transmitter is taken as
// always empty, so its pending bit follows its enable alone.
module mu_irq_logic #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_we,
    input  logic [1:0]       ien_wdata,
    input  logic [CNT_W-1:0] level,
    output logic [1:0]       ien,
    output logic [1:0]       pending,
    output logic             irq
);
    // Enable register: only the two enable bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien <= '0;
        else if (ien_we)
            ien <= ien_wdata;
    end

    // Pending bits and the level interrupt they produce.
    always_comb begin
        pending[0] = ien[0] && (level != '0);
        pending[1] = ien[1];
        irq        = |pending;
    end
endmodule

// File: rtl/mu_regfront.sv
// Register front end for an auxiliary UART: decodes word-aligned offsets,
// drains the receive FIFO on data reads, strobes written bytes out and forms
// the status views. Assumes one bus access at most per cycle; read data is
// combinational and side effects land on the closing edge.
module mu_regfront
    import mu_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        irq
);
    logic             rd_en, wr_en;
    logic             data_pop, fifo_flush, ien_we, tx_we;
    logic [7:0]       head_data;
    logic [CNT_W-1:0] fill_cnt;
    logic [1:0]       ien;
    logic [1:0]       pending;
    logic             has_data;
    logic [23:0]      wdata_unused;

    // Access decode into the individual register actions.
    always_comb begin
        rd_en      = bus_sel && !bus_wr;
        wr_en      = bus_sel && bus_wr;
        data_pop   = rd_en && (bus_addr == OFF_DATA);
        tx_we      = wr_en && (bus_addr == OFF_DATA);
        ien_we     = wr_en && (bus_addr == OFF_IEN);
        fifo_flush = wr_en && (bus_addr == OFF_IID) && bus_wdata[1];
        has_data   = (fill_cnt != '0);
    end

    assign wdata_unused = bus_wdata[31:8];

    mu_rxfifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (rx_valid),
        .push_data  (rx_data),
        .push_ready (rx_ready),
        .pop        (data_pop),
        .flush      (fifo_flush),
        .head_data  (head_data),
        .level      (fill_cnt)
    );

    mu_irq_logic #(.CNT_W(CNT_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_we    (ien_we),
        .ien_wdata (bus_wdata[1:0]),
        .level     (fill_cnt),
        .ien       (ien),
        .pending   (pending),
        .irq       (irq)
    );

    // Transmit strobe: one cycle after each data-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= tx_we;
            if (tx_we)
                tx_byte <= bus_wdata[7:0];
        end
    end

    // Read mux over the register views; zero when no read is selected.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (bus_addr)
                OFF_AGG:   bus_rdata = {31'b0, irq};
                OFF_ENA:   bus_rdata = 32'h1;
                OFF_DATA:  bus_rdata = {24'b0, head_data};
                OFF_IEN:   bus_rdata = FIFO_ON_BITS | {30'b0, ien};
                OFF_IID:   bus_rdata = FIFO_ON_BITS
                                     | (has_data ? 32'h4 : 32'h2)
                                     | {31'b0, (pending == 2'b00)};
                OFF_LSTAT: bus_rdata = LSTAT_BASE | {31'b0, has_data};
                OFF_CTRL:  bus_rdata = 32'h3;
                OFF_XSTAT: bus_rdata = XSTAT_BASE | {31'b0, has_data}
                                     | (32'(fill_cnt) << XSTAT_LVL_LSB);
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mu_regfront_chk.sv
// Property checker for mu_regfront, attached by bind. Observes ports plus the
// FIFO fill count and the enable register.
module mu_regfront_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic [7:0]       tx_byte,
    input logic             irq,
    input logic [CNT_W-1:0] fill_cnt,
    input logic [1:0]       ien
);
    logic data_rd, data_wr, flush_wr, push_ok;
    assign data_rd  = bus_sel && !bus_wr && (bus_addr == 8'h40);
    assign data_wr  = bus_sel && bus_wr && (bus_addr == 8'h40);
    assign flush_wr = bus_sel && bus_wr && (bus_addr == 8'h48) && bus_wdata[1];
    assign push_ok  = rx_valid && rx_ready;

    // R11: count never passes the depth.
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));
    // R11: a full FIFO refuses input.
    a_r11_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == CNT_W'(DEPTH)) |-> !rx_ready);
    // R3: transmit enable alone raises the interrupt.
    a_r3_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ien[1] |-> irq);
    // R3: nothing enabled, no interrupt.
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 2'b00) |-> !irq);
    // R13: data write gives one strobe with the byte.
    a_r13_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));
    // R13: no write, no strobe.
    a_r13_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !tx_valid);
    // R5: flush empties the FIFO.
    a_r5_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> (fill_cnt == '0));
    // R12: pop plus accepted push keeps the count.
    a_r12_pop_push: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && push_ok && fill_cnt != '0) |=> (fill_cnt == $past(fill_cnt)));
    // R7: empty read with no push leaves the FIFO empty.
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && fill_cnt == '0 && !rx_valid) |=> (fill_cnt == '0));
endmodule

bind mu_regfront mu_regfront_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .irq       (irq),
    .fill_cnt  (fill_cnt),
    .ien       (ien)
);

// File: tb/sim_mu_regfront.sv
// Directed bench for mu_regfront: one task per scenario, each checking itself.
// Inputs change on falling edges; read data is sampled mid low phase.
module sim_mu_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mu_regfront u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each access starts at a falling edge and ends at the next one.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_data = b;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
        rd(8'h44, v); chk("R1 ien", v, 32'hC0);
        rd(8'h64, v); chk("R1 xstat", v, 32'h30E);
        rd(8'h54, v); chk("R8 lstat empty", v, 32'h60);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(8'h44, 32'hFF);
        rd(8'h44, v); chk("R2 ien masked", v, 32'hC3);
        chk("R3 tx irq", 32'(irq), 1);
        rd(8'h00, v); chk("R3 agg", v, 1);
        rd(8'h48, v); chk("R4 iid tx", v, 32'hC2);
        wr(8'h44, 32'h1);
        chk("R3 rx en empty", 32'(irq), 0);
        rd(8'h00, v); chk("R3 agg idle", v, 0);
        rd(8'h48, v); chk("R4 iid none", v, 32'hC3);
        push(8'h5A);
        chk("R3 rx irq", 32'(irq), 1);
        rd(8'h48, v); chk("R4 iid rx", v, 32'hC4);
        rd(8'h40, v); chk("R6 pop", v, 32'h5A);
        chk("R3 irq cleared", 32'(irq), 0);
        wr(8'h44, 32'h0);
    endtask

    task automatic t_order_wrap();
        logic [31:0] v;
        push(8'hA1); push(8'hA2); push(8'hA3);
        rd(8'h54, v); chk("R8 lstat data", v, 32'h61);
        rd(8'h64, v); chk("R9 xstat 3", v, 32'h0003_030F);
        for (int i = 0; i < 3; i++) begin
            rd(8'h40, v); chk("R6 order", v, 32'(8'hA1 + i));
        end
        // read pointer now mid-ring; fill to full so it wraps
        for (int i = 0; i < 8; i++) push(8'hB0 + 8'(i));
        chk("R11 full ready", 32'(rx_ready), 0);
        push(8'hEE);
        rd(8'h64, v); chk("R11 full count", v, 32'h0008_030F);
        for (int i = 0; i < 8; i++) begin
            rd(8'h40, v); chk("R6 wrap order", v, 32'(8'hB0 + i));
        end
        chk("R11 ready again", 32'(rx_ready), 1);
        rd(8'h40, v); chk("R7 stale", v, 32'hB0);
        rd(8'h64, v); chk("R7 state kept", v, 32'h30E);
        rd(8'h40, v); chk("R7 stale twice", v, 32'hB0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        push(8'h11); push(8'h12);
        wr(8'h48, 32'h4);
        rd(8'h64, v); chk("R5 no flush", v, 32'h0002_030F);
        rx_valid = 1; rx_data = 8'h99;
        wr(8'h48, 32'h2);
        rx_valid = 0;
        rd(8'h64, v); chk("R5 flushed", v, 32'h30E);
        rd(8'h54, v); chk("R5 lstat", v, 32'h60);
        push(8'h21);
        rd(8'h40, v); chk("R5 after flush", v, 32'h21);
    endtask

    task automatic t_simul();
        logic [31:0] v;
        push(8'hC0); push(8'hC1);
        rx_valid = 1; rx_data = 8'hC2;
        rd(8'h40, v); chk("R12 head", v, 32'hC0);
        rx_valid = 0;
        rd(8'h64, v); chk("R12 count kept", v, 32'h0002_030F);
        rd(8'h40, v); chk("R12 next", v, 32'hC1);
        rd(8'h40, v); chk("R12 pushed", v, 32'hC2);
    endtask

    task automatic t_tx();
        wr(8'h40, 32'h1A5);
        chk("R13 strobe", 32'(tx_valid), 1);
        chk("R13 byte", 32'(tx_byte), 32'hA5);
        @(negedge clk);
        chk("R13 one cycle", 32'(tx_valid), 0);
    endtask

    task automatic t_const();
        logic [31:0] v;
        rd(8'h60, v); chk("R10 ctrl", v, 32'h3);
        rd(8'h04, v); chk("R10 enables", v, 32'h1);
        rd(8'h4C, v); chk("R10 unmapped", v, 0);
        rd(8'h42, v); chk("R10 misaligned", v, 0);
        push(8'h77);
        wr(8'h04, 32'h0); wr(8'h5C, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);
        chk("R10 no tx", 32'(tx_valid), 0);
        rd(8'h04, v); chk("R10 enables kept", v, 32'h1);
        rd(8'h44, v); chk("R10 ien kept", v, 32'hC0);
        rd(8'h64, v); chk("R10 fifo kept", v, 32'h0001_030F);
        rd(8'h40, v); chk("R10 data kept", v, 32'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_irq();
        t_order_wrap();
        t_flush();
        t_simul();
        t_tx();
        t_const();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule